// File: doc/BRIEF.md
# Bit-oriented HDLC frame receiver

This block takes a serial line one bit per enable strobe and turns it back into packets. It looks for the opening and closing delimiter byte `8'h7E`, which arrives as the bit run 0,1,1,1,1,1,1,0. It removes the zero that a transmitter inserts after every five consecutive ones. It packs the remaining payload bits into bytes, least significant bit first. Each byte comes out as a one-cycle beat that carries start-of-packet and end-of-packet marks. A delimiter can close one packet and open the next.

Before the first delimiter, and after an idle run, the receiver hunts and discards every bit until it sees a delimiter. A run of seven or more ones is the idle code, which the `line_idle` status shows. If the idle code arrives inside a packet, that packet is cut short and its last beat is marked as an error. A packet whose payload is not a whole number of bytes also ends with an error mark. The receiver does not check the frame check sequence or filter addresses. It buffers no more than one byte.

Top module: `hdlc_bit_rx`

## Requirements
- R1: The delimiter bits never appear in the output. Between two delimiters, the payload bytes come out in order, each as one beat with `byte_valid` high.
- R2: A 0 that follows five consecutive 1s inside a packet is dropped and adds no bit to the payload.
- R3: One delimiter closes the current packet and also opens the next one. No second delimiter is needed between back-to-back packets.
- R4: `line_idle` rises on the strobe that delivers the seventh consecutive 1. It stays high while more 1s arrive and falls on the strobe that delivers the next 0.
- R5: Two delimiters with no payload between them produce no output beat.
- R6: When a packet closes with a payload bit count that is not a multiple of 8, its last beat has `byte_eop` and `byte_err` high. Such a packet produces max(N,1) beats, where N is the number of whole bytes.
- R7: An idle run inside a packet ends that packet with a beat that has `byte_eop` and `byte_err` high. The receiver then ignores bits until the next delimiter.
- R8: Payload bits are packed first-received into bit 0. `byte_sop` marks the first beat of a packet and `byte_eop` marks the last one. The last byte is held back and emitted only when the closing delimiter arrives. `byte_sop`, `byte_eop` and `byte_err` are low when `byte_valid` is low.
- R9: An output beat appears only in the clock cycle right after an edge where `bit_en` was sampled high.
- R10: After reset all outputs are low. Bits received before the first delimiter produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Strobe: `bit_in` holds a new line bit in this cycle |
| bit_in | input | 1 | Serial line bit |
| byte_valid | output | 1 | Output beat present |
| byte_data | output | 8 | Payload byte, first-received bit in bit 0 |
| byte_sop | output | 1 | First byte of a packet |
| byte_eop | output | 1 | Last byte of a packet |
| byte_err | output | 1 | Packet ended misaligned or on an idle run; valid with `byte_eop` |
| line_idle | output | 1 | Idle code (seven or more ones) is on the line |

## Verification
The assertions assume that `bit_en` is low during reset. They also assume the transmitter stuffs correctly, so the leading 0 of a delimiter never follows five payload 1s. The bench meets both conditions: its encoder inserts a stuffing zero after every fifth payload 1 and restarts its run count at each delimiter. It only drives raw unstuffed runs on purpose, for the idle, misalignment and pre-sync cases. Strobe spacing changes between packets, from every cycle to every third cycle. This keeps the beat-timing property exercised at both rates.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int BYTE_W     = 8;
    localparam int STUFF_ONES = 5;
    localparam int FLAG_ONES  = 6;
    localparam int IDLE_ONES  = 7;
    localparam int RUN_W      = $clog2(IDLE_ONES + 1);
    localparam int HOLD_BITS  = FLAG_ONES + 1;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_DATA,
        EV_DROP,
        EV_FLAG,
        EV_IDLE
    } bit_ev_t;
endpackage

// File: rtl/hdlc_rx_classify.sv
module hdlc_rx_classify
    import hdlc_rx_pkg::*;
#(
    parameter int STUFF_N = STUFF_ONES,
    parameter int FLAG_N  = FLAG_ONES,
    parameter int IDLE_N  = IDLE_ONES,
    parameter int CNT_W   = $clog2(IDLE_N + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_en,
    input  logic    bit_in,
    output bit_ev_t ev,
    output logic    idle
);
    localparam logic [CNT_W-1:0] RUN_STUFF = CNT_W'(STUFF_N);
    localparam logic [CNT_W-1:0] RUN_FLAG  = CNT_W'(FLAG_N);
    localparam logic [CNT_W-1:0] RUN_IDLE  = CNT_W'(IDLE_N);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             idle;
        logic             synced;
    } cls_state_t;

    cls_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ev   = EV_NONE;
        if (bit_en) begin
            if (bit_in) begin
                if (st_q.run == RUN_IDLE - 1'b1) begin
                    // seventh one in a row: idle code
                    st_d.run    = RUN_IDLE;
                    st_d.idle   = 1'b1;
                    st_d.synced = 1'b0;
                    ev          = EV_IDLE;
                end else if (st_q.run != RUN_IDLE) begin
                    st_d.run = st_q.run + 1'b1;
                    ev       = st_q.synced ? EV_DATA : EV_NONE;
                end
            end else begin
                st_d.run  = '0;
                st_d.idle = 1'b0;
                if (st_q.run == RUN_FLAG) begin
                    ev          = EV_FLAG;
                    st_d.synced = 1'b1;
                end else if (!st_q.synced) begin
                    ev = EV_NONE;
                end else if (st_q.run == RUN_STUFF) begin
                    ev = EV_DROP;
                end else begin
                    ev = EV_DATA;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle = st_q.idle;
endmodule

// File: rtl/hdlc_rx_delay.sv
module hdlc_rx_delay #(
    parameter int DEPTH  = hdlc_rx_pkg::HOLD_BITS,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_bit,
    input  logic clear,
    output logic out_vld,
    output logic out_bit
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]  sr;
        logic [FILL_W-1:0] fill;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        out_vld = 1'b0;
        out_bit = st_q.sr[0];
        if (clear) begin
            st_d.fill = '0;
        end else if (push) begin
            st_d.sr = {push_bit, st_q.sr[DEPTH-1:1]};
            if (st_q.fill == FULL) out_vld = 1'b1;
            else                   st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hdlc_rx_assemble.sv
module hdlc_rx_assemble #(
    parameter int BYTE_W = hdlc_rx_pkg::BYTE_W,
    parameter int CNT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              close,
    input  logic              abort,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              sop,
    output logic              eop,
    output logic              err
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] pend;
        logic              pend_v;
        logic              first;
        logic              o_valid;
        logic [BYTE_W-1:0] o_data;
        logic              o_sop;
        logic              o_eop;
        logic              o_err;
    } asm_state_t;

    asm_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.o_valid = 1'b0;
        st_d.o_sop   = 1'b0;
        st_d.o_eop   = 1'b0;
        st_d.o_err   = 1'b0;
        if (bit_vld) begin
            st_d.acc = {bit_val, st_q.acc[BYTE_W-1:1]};
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                if (st_q.pend_v) begin
                    st_d.o_valid = 1'b1;
                    st_d.o_data  = st_q.pend;
                    st_d.o_sop   = st_q.first;
                    st_d.first   = 1'b0;
                end
                st_d.pend   = {bit_val, st_q.acc[BYTE_W-1:1]};
                st_d.pend_v = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (close || abort) begin
            if (st_q.pend_v || st_q.cnt != '0) begin
                st_d.o_valid = 1'b1;
                st_d.o_data  = st_q.pend_v ? st_q.pend : st_q.acc;
                st_d.o_sop   = st_q.first;
                st_d.o_eop   = 1'b1;
                st_d.o_err   = abort || (st_q.cnt != '0);
            end
            st_d.cnt    = '0;
            st_d.pend_v = 1'b0;
            st_d.first  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.o_valid;
    assign data  = st_q.o_data;
    assign sop   = st_q.o_sop;
    assign eop   = st_q.o_eop;
    assign err   = st_q.o_err;
endmodule

// File: rtl/hdlc_bit_rx.sv
module hdlc_bit_rx
    import hdlc_rx_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_sop,
    output logic              byte_eop,
    output logic              byte_err,
    output logic              line_idle
);
    bit_ev_t ev;
    logic    dly_vld;
    logic    dly_bit;
    logic    is_flag;
    logic    is_idle;

    assign is_flag = (ev == EV_FLAG);
    assign is_idle = (ev == EV_IDLE);

    hdlc_rx_classify #(
        .STUFF_N(STUFF_ONES),
        .FLAG_N (FLAG_ONES),
        .IDLE_N (IDLE_ONES)
    ) u_classify (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_en(bit_en),
        .bit_in(bit_in),
        .ev    (ev),
        .idle  (line_idle)
    );

    hdlc_rx_delay #(
        .DEPTH(HOLD_BITS)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ev == EV_DATA),
        .push_bit(bit_in),
        .clear   (is_flag || is_idle),
        .out_vld (dly_vld),
        .out_bit (dly_bit)
    );

    hdlc_rx_assemble #(
        .BYTE_W(DATA_W)
    ) u_assemble (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_vld(dly_vld),
        .bit_val(dly_bit),
        .close  (is_flag),
        .abort  (is_idle),
        .valid  (byte_valid),
        .data   (byte_data),
        .sop    (byte_sop),
        .eop    (byte_eop),
        .err    (byte_err)
    );
endmodule

// File: rtl/hdlc_bit_rx_chk.sv
module hdlc_bit_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              bit_in,
    input logic              byte_valid,
    input logic [DATA_W-1:0] byte_data,
    input logic              byte_sop,
    input logic              byte_eop,
    input logic              byte_err,
    input logic              line_idle
);
    AST_IDLE_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_idle) |-> $past(bit_en && bit_in)); // R4
    AST_IDLE_CLEARS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bit_in) |=> !line_idle); // R4
    AST_ERR_ONLY_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_err |-> byte_eop); // R6
    AST_ABORT_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && $rose(line_idle)) |-> (byte_eop && byte_err)); // R7
    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> !(byte_sop || byte_eop || byte_err)); // R8
    AST_BEAT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(bit_en)); // R9
    wire unused_ok = &{1'b0, byte_data};
endmodule

bind hdlc_bit_rx hdlc_bit_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/hdlc_bit_rx_bench.sv
module hdlc_bit_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n, bit_en, bit_in;
    logic       byte_valid, byte_sop, byte_eop, byte_err, line_idle;
    logic [7:0] byte_data;

    int checks = 0, fails = 0, gap = 0, tx_run = 0, rx_n = 0;
    logic [10:0] rx_beat [0:255];
    logic [7:0]  pay [0:15];

    always #5 clk = ~clk;

    hdlc_bit_rx u_hdlc_bit_rx (.*);

    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            if (rx_n < 256) rx_beat[rx_n] = {byte_sop, byte_eop, byte_err, byte_data};
            rx_n = rx_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_en = 1'b1;
        bit_in = b;
        @(posedge clk); #1;
        bit_en = 1'b0;
        repeat (gap) begin @(posedge clk); #1; end
    endtask

    task automatic send_raw_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        tx_run = 0;
    endtask

    task automatic send_flag();
        send_raw_byte(8'h7E);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) begin
                tx_run++;
                if (tx_run == 5) begin send_bit(1'b0); tx_run = 0; end
            end else begin
                tx_run = 0;
            end
        end
    endtask

    task automatic send_pkt(input int n);
        for (int i = 0; i < n; i++) send_byte(pay[i]);
        send_flag();
    endtask

    task automatic settle();
        repeat (3) begin @(posedge clk); #1; end
    endtask

    task automatic check_pkt(input int n, input string tag);
        settle();
        chk({tag, " beat count"}, rx_n, n);
        for (int i = 0; i < n && i < rx_n; i++)
            chk({tag, " beat"}, {21'd0, rx_beat[i]}, {21'd0, (i == 0), (i == n - 1), 1'b0, pay[i]});
        rx_n = 0;
    endtask

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R10: reset state
        chk("R10 valid after reset", byte_valid, 0);
        chk("R10 idle after reset", line_idle, 0);
        chk("R10 marks after reset", {byte_sop, byte_eop, byte_err}, 0);

        // R10: bits before the first delimiter are ignored
        send_raw_byte(8'h55);
        send_raw_byte(8'h0F);
        settle();
        chk("R10 no output before sync", rx_n, 0);
        send_flag();
        pay[0] = 8'hA3;
        send_pkt(1);
        check_pkt(1, "R10 first packet");

        // R1 R2 R3 R8: sweep of lengths and patterns, shared delimiters
        for (int p = 0; p < 3; p++) begin
            for (int n = 1; n <= 8; n++) begin
                gap = (n + p) % 3;
                for (int i = 0; i < n; i++) begin
                    case (p)
                        0: pay[i] = 8'((i * 29 + n * 7 + 1) & 255);
                        1: pay[i] = (i % 2 == 0) ? 8'hFF : 8'hF8;
                        default: case (i % 4)
                            0: pay[i] = 8'h7E;
                            1: pay[i] = 8'h7D;
                            2: pay[i] = 8'h3F;
                            default: pay[i] = 8'hFC;
                        endcase
                    endcase
                end
                send_pkt(n);
                if (p == 0)      check_pkt(n, "R1 R8 sweep");
                else if (p == 1) check_pkt(n, "R2 stuffing");
                else             check_pkt(n, "R3 shared flag");
            end
        end
        gap = 0;

        // R5: empty packets
        send_flag(); send_flag(); send_flag();
        settle();
        chk("R5 empty packets", rx_n, 0);
        rx_n = 0;
        pay[0] = 8'h11; pay[1] = 8'h80;
        send_pkt(2);
        check_pkt(2, "R5 after empties");

        // R6: misaligned endings
        for (int k = 1; k < 8; k++) begin
            for (int n = 0; n < 3; n++) begin
                int exp_n;
                exp_n = (n == 0) ? 1 : n;
                for (int i = 0; i < n; i++) send_byte(8'(8'h41 + i));
                for (int j = 0; j < k; j++) send_bit(1'b0);
                tx_run = 0;
                send_flag();
                settle();
                chk("R6 beat count", rx_n, exp_n);
                if (rx_n >= 1)
                    chk("R6 last beat marks", rx_beat[rx_n - 1][10:8], {(rx_n == 1), 1'b1, 1'b1});
                rx_n = 0;
            end
        end

        // R4 R7: idle run inside a packet
        for (int n = 1; n <= 3; n++) begin
            int exp_n;
            exp_n = (n == 1) ? 1 : n - 1;
            for (int i = 0; i < n; i++) send_byte(8'(8'h12 + 8'h22 * i));
            for (int j = 0; j < 6; j++) send_bit(1'b1);
            chk("R4 no idle at six ones", line_idle, 0);
            send_bit(1'b1);
            chk("R4 idle at seventh one", line_idle, 1);
            settle();
            chk("R7 beat count on abort", rx_n, exp_n);
            if (rx_n >= 1)
                chk("R7 abort marks", rx_beat[rx_n - 1][9:8], 2'b11);
            rx_n = 0;
            for (int j = 0; j < 3; j++) send_bit(1'b1);
            chk("R4 idle holds", line_idle, 1);
            send_bit(1'b0);
            chk("R4 idle clears on zero", line_idle, 0);
            tx_run = 0;
            send_byte(8'h66);
            settle();
            chk("R7 hunting after idle", rx_n, 0);
            rx_n = 0;
            send_flag();
            pay[0] = 8'h5A;
            send_pkt(1);
            check_pkt(1, "R7 resync");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule